// File: doc/BRIEF.md
# Register-Started Memory-to-Stream Mover

This block is the read half of a simple-mode DMA. Software writes a source byte address and then a byte count. The count write itself is the start command. The block then fetches the words from memory in bursts and sends them out as one AXI4-Stream packet. TKEEP marks the valid bytes of the final beat, and TLAST is raised on that beat. There is no descriptor chain and no realignment. A start address that is not word aligned is refused and flagged as an error.

Software reaches the block through a four-word register port. Word 0 is control, word 1 is status, word 2 is the source address and word 3 is the byte count. The read data of this port is combinational. A pending completion bit and a pending error bit are acknowledged by writing 1 to them. A single interrupt line combines the two pending bits, each gated by its own enable. A soft reset lets an in-flight memory burst run to its end, discarding the data, before the channel is idle again. A reset-done status bit tells software when that has finished.

The memory side is a request/grant port: one request carries an address and a beat count, one burst is outstanding at a time, and the response words are handshaken with valid/ready.

Top module: `mm2s_mover`

## Requirements
- R1: After reset, status (word 1) reads 0x10. The fields are bit0 busy, bit1 done-pending, bit2 error-pending, bit3 halted and bit4 reset-done. After reset, irq, m_tvalid and rd_req are low.
- R2: Only the low 14 bits of a count write (word 3) are kept. Writing 0x4008 moves 8 bytes and reads back as 8. Writing 0x4000 or 0 starts nothing.
- R3: A start with a source address (word 2) that is not a multiple of 4 issues no memory request. It sets error-pending and halted. While halted, count writes are ignored.
- R4: Memory requests cover the transfer with consecutive word addresses. Each request asks for min(remaining beats, 16) beats, so only the last request is shorter.
- R5: The stream carries the memory words in address order, one beat per word, ceil(count/4) beats in total. TLAST is high on the final beat only.
- R6: On the final beat, TKEEP is 0x1, 0x3 or 0x7 when count mod 4 is 1, 2 or 3, and 0xF otherwise. Every other beat has TKEEP 0xF.
- R7: Done-pending is set when the final beat is accepted. Writing status with bit1 set clears it, and writing bit2 clears error-pending.
- R8: Writes to the count or the source address while busy are ignored. They change neither the transfer in progress nor the stored values.
- R9: irq is high exactly when (done-pending and control bit0) or (error-pending and control bit1).
- R10: Writing control bit2 is a soft reset. It clears all registers and the halted state at once. An in-flight burst is drained with m_tvalid low while reset-done reads 0, and then the channel accepts new transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data (combinational) |
| irq | output | 1 | Interrupt |
| rd_req | output | 1 | Memory burst request |
| rd_addr | output | ADDR_W | Burst start byte address |
| rd_len | output | BLEN_W | Burst length in beats |
| rd_gnt | input | 1 | Request accepted |
| rsp_valid | input | 1 | Response word valid |
| rsp_data | input | DATA_W | Response word |
| rsp_ready | output | 1 | Response word accepted |
| m_tdata | output | DATA_W | Stream data |
| m_tkeep | output | KEEP_W | Stream byte enables |
| m_tlast | output | 1 | Final beat of packet |
| m_tvalid | output | 1 | Stream beat valid |
| m_tready | input | 1 | Stream sink ready |

## Verification
The bench targets count values whose last beat is partial. If the tail mask were computed from the wrong bits, the final TKEEP would be wrong. It also uses lengths just past a multiple of the burst size and the 16383-byte maximum. Faulty burst splitting there would ask for a zero-length or oversized last request, or would skip addresses. A count write during a long transfer with a stalling sink catches a design that restarts or overwrites its registers mid-packet. A misaligned start, and a soft reset with the sink held off mid-burst, catch designs that touch memory anyway, stay halted, or leak the drained words onto the stream.

// File: rtl/mm2s_pkg.sv
package mm2s_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_REQ,
    ST_DATA,
    ST_FLUSH,
    ST_HALT
  } mover_state_e;

  localparam logic [1:0] REG_CTRL = 2'd0;
  localparam logic [1:0] REG_STAT = 2'd1;
  localparam logic [1:0] REG_SRC  = 2'd2;
  localparam logic [1:0] REG_LEN  = 2'd3;

  localparam int CTRL_DONE_EN = 0;
  localparam int CTRL_ERR_EN  = 1;
  localparam int CTRL_SRST    = 2;

  localparam int STAT_BUSY  = 0;
  localparam int STAT_DONE  = 1;
  localparam int STAT_ERR   = 2;
  localparam int STAT_HALT  = 3;
  localparam int STAT_RDONE = 4;
endpackage

// File: rtl/mm2s_rst_sync.sv
module mm2s_rst_sync (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_n_out = sync_q[1];
endmodule

// File: rtl/mm2s_regs.sv
module mm2s_regs
  import mm2s_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 14
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq_o,
  input  logic              eng_busy,
  input  logic              eng_halted,
  input  logic              eng_flushing,
  input  logic              eng_done,
  input  logic              eng_err,
  output logic              start_o,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [LEN_W-1:0]  start_len_o,
  output logic              soft_rst_o
);
  logic              done_en_q, done_en_d, err_en_q, err_en_d;
  logic              done_pend_q, done_pend_d, err_pend_q, err_pend_d;
  logic [ADDR_W-1:0] src_q, src_d;
  logic [LEN_W-1:0]  len_q, len_d;
  logic              wr_ctrl, wr_stat, wr_src, wr_len, accept;

  assign wr_ctrl = reg_wr && (reg_addr == REG_CTRL);
  assign wr_stat = reg_wr && (reg_addr == REG_STAT);
  assign wr_src  = reg_wr && (reg_addr == REG_SRC);
  assign wr_len  = reg_wr && (reg_addr == REG_LEN);
  assign accept  = !eng_busy && !eng_halted;

  assign soft_rst_o   = wr_ctrl && reg_wdata[CTRL_SRST];
  assign start_o      = wr_len && accept && (|reg_wdata[LEN_W-1:0]);
  assign start_addr_o = src_q;
  assign start_len_o  = reg_wdata[LEN_W-1:0];
  assign irq_o        = (done_pend_q && done_en_q) || (err_pend_q && err_en_q);

  always_comb begin
    done_en_d   = done_en_q;
    err_en_d    = err_en_q;
    done_pend_d = done_pend_q;
    err_pend_d  = err_pend_q;
    src_d       = src_q;
    len_d       = len_q;
    if (wr_ctrl) begin
      done_en_d = reg_wdata[CTRL_DONE_EN];
      err_en_d  = reg_wdata[CTRL_ERR_EN];
    end
    if (wr_src && accept) src_d = reg_wdata[ADDR_W-1:0];
    if (wr_len && accept) len_d = reg_wdata[LEN_W-1:0];
    if (wr_stat && reg_wdata[STAT_DONE]) done_pend_d = 1'b0;
    if (wr_stat && reg_wdata[STAT_ERR])  err_pend_d  = 1'b0;
    if (eng_done) done_pend_d = 1'b1;
    if (eng_err)  err_pend_d  = 1'b1;
    if (soft_rst_o) begin
      done_en_d   = 1'b0;
      err_en_d    = 1'b0;
      done_pend_d = 1'b0;
      err_pend_d  = 1'b0;
      src_d       = '0;
      len_d       = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_en_q   <= 1'b0;
      err_en_q    <= 1'b0;
      done_pend_q <= 1'b0;
      err_pend_q  <= 1'b0;
      src_q       <= '0;
      len_q       <= '0;
    end else begin
      done_en_q   <= done_en_d;
      err_en_q    <= err_en_d;
      done_pend_q <= done_pend_d;
      err_pend_q  <= err_pend_d;
      src_q       <= src_d;
      len_q       <= len_d;
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_CTRL: begin
        reg_rdata[CTRL_DONE_EN] = done_en_q;
        reg_rdata[CTRL_ERR_EN]  = err_en_q;
      end
      REG_STAT: begin
        reg_rdata[STAT_BUSY]  = eng_busy;
        reg_rdata[STAT_DONE]  = done_pend_q;
        reg_rdata[STAT_ERR]   = err_pend_q;
        reg_rdata[STAT_HALT]  = eng_halted;
        reg_rdata[STAT_RDONE] = !eng_flushing;
      end
      REG_SRC: reg_rdata[ADDR_W-1:0] = src_q;
      default: reg_rdata[LEN_W-1:0]  = len_q;
    endcase
  end

  // R8
  len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_len && eng_busy) |=> $stable(len_q));
  // R7
  done_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_stat && reg_wdata[STAT_DONE] && !eng_done) |=> !done_pend_q);
  // R9
  irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> (done_pend_q || err_pend_q));
endmodule

// File: rtl/mm2s_engine.sv
module mm2s_engine
  import mm2s_pkg::*;
#(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int DATA_W    = 32,
  parameter int BURST_MAX = 16,
  localparam int KEEP_W   = DATA_W / 8,
  localparam int BYTE_SH  = $clog2(KEEP_W),
  localparam int BEAT_W   = LEN_W + 1 - BYTE_SH,
  localparam int BLEN_W   = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [LEN_W-1:0]  start_len_i,
  input  logic              soft_rst_i,
  output logic              busy_o,
  output logic              halted_o,
  output logic              flushing_o,
  output logic              done_o,
  output logic              err_o,
  output logic              rd_req_o,
  output logic [ADDR_W-1:0] rd_addr_o,
  output logic [BLEN_W-1:0] rd_len_o,
  input  logic              rd_gnt_i,
  input  logic              rsp_valid_i,
  input  logic [DATA_W-1:0] rsp_data_i,
  output logic              rsp_ready_o,
  output logic [DATA_W-1:0] m_tdata_o,
  output logic [KEEP_W-1:0] m_tkeep_o,
  output logic              m_tlast_o,
  output logic              m_tvalid_o,
  input  logic              m_tready_i
);
  mover_state_e       state_q, state_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [BEAT_W-1:0]  beats_q, beats_d, beats_calc;
  logic [BLEN_W-1:0]  burst_q, burst_d;
  logic [BYTE_SH-1:0] tail_q, tail_d;
  logic [LEN_W:0]     len_pad;
  logic               beat_fire, last_beat, misaligned;

  assign len_pad    = {1'b0, start_len_i} + (LEN_W+1)'(KEEP_W - 1);
  assign beats_calc = BEAT_W'(len_pad >> BYTE_SH);
  assign misaligned = |start_addr_i[BYTE_SH-1:0];
  assign last_beat  = (state_q == ST_DATA) && (beats_q == BEAT_W'(1));
  assign beat_fire  = (state_q == ST_DATA) && rsp_valid_i && m_tready_i;

  assign rd_req_o    = (state_q == ST_REQ);
  assign rd_addr_o   = addr_q;
  assign rd_len_o    = (beats_q > BEAT_W'(BURST_MAX)) ? BLEN_W'(BURST_MAX) : BLEN_W'(beats_q);
  assign rsp_ready_o = ((state_q == ST_DATA) && m_tready_i) || (state_q == ST_FLUSH);
  assign m_tvalid_o  = (state_q == ST_DATA) && rsp_valid_i;
  assign m_tdata_o   = rsp_data_i;
  assign m_tlast_o   = last_beat;
  assign busy_o      = (state_q == ST_REQ) || (state_q == ST_DATA) || (state_q == ST_FLUSH);
  assign halted_o    = (state_q == ST_HALT);
  assign flushing_o  = (state_q == ST_FLUSH);

  for (genvar b = 0; b < KEEP_W; b++) begin : g_keep
    assign m_tkeep_o[b] = !last_beat || (tail_q == '0) || (BYTE_SH'(b) < tail_q);
  end

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    beats_d = beats_q;
    burst_d = burst_q;
    tail_d  = tail_q;
    done_o  = 1'b0;
    err_o   = 1'b0;
    case (state_q)
      ST_IDLE: if (start_i) begin
        if (misaligned) begin
          state_d = ST_HALT;
          err_o   = 1'b1;
        end else begin
          addr_d  = start_addr_i;
          beats_d = beats_calc;
          tail_d  = start_len_i[BYTE_SH-1:0];
          state_d = ST_REQ;
        end
      end
      ST_REQ: if (rd_gnt_i) begin
        burst_d = rd_len_o;
        state_d = ST_DATA;
      end
      ST_DATA: if (beat_fire) begin
        addr_d  = addr_q + ADDR_W'(KEEP_W);
        beats_d = beats_q - BEAT_W'(1);
        burst_d = burst_q - BLEN_W'(1);
        if (beats_q == BEAT_W'(1)) begin
          state_d = ST_IDLE;
          done_o  = 1'b1;
        end else if (burst_q == BLEN_W'(1)) begin
          state_d = ST_REQ;
        end
      end
      ST_FLUSH: if (rsp_valid_i) begin
        burst_d = burst_q - BLEN_W'(1);
        if (burst_q == BLEN_W'(1)) state_d = ST_IDLE;
      end
      ST_HALT: state_d = ST_HALT;
      default: state_d = ST_IDLE;
    endcase
    if (soft_rst_i) begin
      if ((state_q == ST_DATA) && !(beat_fire && (burst_q == BLEN_W'(1)))) state_d = ST_FLUSH;
      else if (state_q != ST_FLUSH) state_d = ST_IDLE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      beats_q <= '0;
      burst_q <= '0;
      tail_q  <= '0;
    end else begin
      state_q <= state_d;
      addr_q  <= addr_d;
      beats_q <= beats_d;
      burst_q <= burst_d;
      tail_q  <= tail_d;
    end
  end

  // R4
  req_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_req_o |-> (rd_len_o != '0) && (rd_len_o <= BLEN_W'(BURST_MAX)));
  // R3
  misalign_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && start_i && misaligned && !soft_rst_i) |=> (halted_o && !rd_req_o));
  // R5
  tlast_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_tvalid_o && m_tready_i && m_tlast_o) |=> !m_tvalid_o);
  // R10
  flush_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    soft_rst_i |=> !m_tvalid_o);
endmodule

// File: rtl/mm2s_mover.sv
module mm2s_mover #(
  parameter int ADDR_W    = 32,
  parameter int LEN_W     = 14,
  parameter int DATA_W    = 32,
  parameter int BURST_MAX = 16,
  localparam int KEEP_W   = DATA_W / 8,
  localparam int BLEN_W   = $clog2(BURST_MAX + 1)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [1:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              irq,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [BLEN_W-1:0] rd_len,
  input  logic              rd_gnt,
  input  logic              rsp_valid,
  input  logic [DATA_W-1:0] rsp_data,
  output logic              rsp_ready,
  output logic [DATA_W-1:0] m_tdata,
  output logic [KEEP_W-1:0] m_tkeep,
  output logic              m_tlast,
  output logic              m_tvalid,
  input  logic              m_tready
);
  logic              rst_n_s;
  logic              busy, halted, flushing, done_ev, err_ev, start, soft_rst;
  logic [ADDR_W-1:0] start_addr;
  logic [LEN_W-1:0]  start_len;

  mm2s_rst_sync u_rst_sync (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_s)
  );

  mm2s_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .reg_wr       (reg_wr),
    .reg_addr     (reg_addr),
    .reg_wdata    (reg_wdata),
    .reg_rdata    (reg_rdata),
    .irq_o        (irq),
    .eng_busy     (busy),
    .eng_halted   (halted),
    .eng_flushing (flushing),
    .eng_done     (done_ev),
    .eng_err      (err_ev),
    .start_o      (start),
    .start_addr_o (start_addr),
    .start_len_o  (start_len),
    .soft_rst_o   (soft_rst)
  );

  mm2s_engine #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .DATA_W(DATA_W), .BURST_MAX(BURST_MAX)
  ) u_engine (
    .clk          (clk),
    .rst_n        (rst_n_s),
    .start_i      (start),
    .start_addr_i (start_addr),
    .start_len_i  (start_len),
    .soft_rst_i   (soft_rst),
    .busy_o       (busy),
    .halted_o     (halted),
    .flushing_o   (flushing),
    .done_o       (done_ev),
    .err_o        (err_ev),
    .rd_req_o     (rd_req),
    .rd_addr_o    (rd_addr),
    .rd_len_o     (rd_len),
    .rd_gnt_i     (rd_gnt),
    .rsp_valid_i  (rsp_valid),
    .rsp_data_i   (rsp_data),
    .rsp_ready_o  (rsp_ready),
    .m_tdata_o    (m_tdata),
    .m_tkeep_o    (m_tkeep),
    .m_tlast_o    (m_tlast),
    .m_tvalid_o   (m_tvalid),
    .m_tready_i   (m_tready)
  );
endmodule

// File: tb/mm2s_mover_bench.sv
module mm2s_mover_bench;
  localparam int BMAX = 16;
  localparam logic [1:0] A_CTRL = 2'd0, A_STAT = 2'd1, A_SRC = 2'd2, A_LEN = 2'd3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic        reg_wr = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        irq, rd_req, rsp_ready;
  logic [31:0] rd_addr;
  logic [4:0]  rd_len;
  logic        rd_gnt = 1'b0, rsp_valid = 1'b0, m_tready = 1'b0;
  logic [31:0] rsp_data = 32'd0;
  logic [31:0] m_tdata;
  logic [3:0]  m_tkeep;
  logic        m_tlast, m_tvalid;

  mm2s_mover u_mm2s_mover (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .rd_req(rd_req), .rd_addr(rd_addr), .rd_len(rd_len), .rd_gnt(rd_gnt),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_ready(rsp_ready),
    .m_tdata(m_tdata), .m_tkeep(m_tkeep), .m_tlast(m_tlast),
    .m_tvalid(m_tvalid), .m_tready(m_tready)
  );

  int checks = 0, fails = 0;
  int gnt_pct = 60, vld_pct = 75, rdy_pct = 80;
  int mem_left = 0, exp_req_left = 0, exp_str_left = 0;
  int beats_seen = 0, bursts_seen = 0;
  logic [31:0] mem_addr = 32'd0, exp_req_addr = 32'd0, exp_str_addr = 32'd0;
  logic [3:0]  exp_keep = 4'hF;
  logic gnt_fire = 1'b0, rsp_fire = 1'b0, snk_fire = 1'b0;
  logic [31:0] cap_addr, cap_data;
  logic [4:0]  cap_len;
  logic [3:0]  cap_keep;
  logic        cap_last;
  bit          finished = 1'b0;

  function automatic logic [31:0] mem_word(logic [31:0] a);
    return {~a[15:0], a[15:0]} ^ 32'h1357_2468;
  endfunction
  function automatic int beats_of(int len);
    return (len + 3) / 4;
  endfunction
  function automatic logic [3:0] last_keep(int len);
    case (len % 4)
      1: return 4'h1;
      2: return 4'h3;
      3: return 4'h7;
      default: return 4'hF;
    endcase
  endfunction
  function automatic int min_burst(int left);
    return (left > BMAX) ? BMAX : left;
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // memory responder and stream sink
  always @(negedge clk) begin
    if (gnt_fire) begin
      chk("R4 burst address", cap_addr, exp_req_addr);
      chk("R4 burst length", 32'(cap_len), 32'(min_burst(exp_req_left)));
      exp_req_addr += 32'(cap_len) * 4;
      exp_req_left -= int'(cap_len);
      bursts_seen++;
      mem_addr = cap_addr;
      mem_left = int'(cap_len);
    end
    if (rsp_fire) begin
      mem_addr += 4;
      mem_left--;
    end
    if (snk_fire) begin
      if (exp_str_left <= 0) chk("R5 unexpected beat", 32'd1, 32'd0);
      else begin
        chk("R5 beat data", cap_data, mem_word(exp_str_addr));
        chk("R5 tlast", 32'(cap_last), 32'(exp_str_left == 1));
        chk("R6 tkeep", 32'(cap_keep), (exp_str_left == 1) ? 32'(exp_keep) : 32'hF);
      end
      exp_str_addr += 4;
      exp_str_left--;
      beats_seen++;
    end
    rd_gnt    = rd_req && (mem_left == 0) && (($urandom % 100) < gnt_pct);
    rsp_valid = (mem_left > 0) && ((rsp_valid && !rsp_fire) || (($urandom % 100) < vld_pct));
    rsp_data  = mem_word(mem_addr);
    m_tready  = (($urandom % 100) < rdy_pct);
    #1;
    gnt_fire = rd_req && rd_gnt;
    cap_addr = rd_addr;
    cap_len  = rd_len;
    rsp_fire = rsp_valid && rsp_ready;
    snk_fire = m_tvalid && m_tready;
    cap_data = m_tdata;
    cap_keep = m_tkeep;
    cap_last = m_tlast;
  end

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #2;
    d = reg_rdata;
  endtask

  task automatic begin_xfer(logic [31:0] addr, logic [31:0] wval, int len);
    wr(A_SRC, addr);
    exp_req_addr = addr;  exp_req_left = beats_of(len);
    exp_str_addr = addr;  exp_str_left = beats_of(len);
    exp_keep = last_keep(len);
    beats_seen = 0;
    wr(A_LEN, wval);
  endtask

  task automatic wait_idle(output logic [31:0] v);
    int guard = 0;
    do begin rd(A_STAT, v); guard++; end while (v[0] && guard < 30000);
  endtask

  task automatic run_xfer(logic [31:0] addr, logic [31:0] wval, int len);
    logic [31:0] v;
    begin_xfer(addr, wval, len);
    wait_idle(v);
    chk("R5 beat count", 32'(beats_seen), 32'(beats_of(len)));
    chk("R4 all beats requested", 32'(exp_req_left), 32'd0);
    chk("R7 done pending set", 32'(v[1]), 32'd1);
    wr(A_STAT, 32'h2);
    rd(A_STAT, v);
    chk("R7 ack clears done", 32'(v[1]), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int b0, len;
    logic [31:0] a;
    void'($urandom(32'h5EED_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(A_STAT, v);
    chk("R1 status after reset", v, 32'h10);
    chk("R1 irq low", 32'(irq), 32'd0);
    chk("R1 tvalid low", 32'(m_tvalid), 32'd0);
    chk("R1 rd_req low", 32'(rd_req), 32'd0);

    // R2 zero and truncated-to-zero counts start nothing
    wr(A_LEN, 32'h0);
    wr(A_LEN, 32'h4000);
    repeat (5) @(negedge clk);
    rd(A_STAT, v);
    chk("R2 zero count not busy", 32'(v[0]), 32'd0);
    chk("R2 zero count no request", 32'(bursts_seen), 32'd0);
    rd(A_LEN, v);
    chk("R2 truncated count reads zero", v, 32'd0);

    // R2 upper bits dropped
    run_xfer(32'h0000_1000, 32'h4008, 8);
    rd(A_LEN, v);
    chk("R2 count reads back 14 bits", v, 32'd8);

    // R6 / R4 directed lengths
    rdy_pct = 100;
    run_xfer(32'h0000_1100, 1, 1);
    run_xfer(32'h0000_1200, 2, 2);
    run_xfer(32'h0000_1300, 3, 3);
    run_xfer(32'h0000_1400, 4, 4);
    run_xfer(32'h0000_1500, 64, 64);
    run_xfer(32'h0000_1600, 65, 65);
    run_xfer(32'h0000_1700, 131, 131);

    // R5 random traffic
    for (int i = 0; i < 12; i++) begin
      len = 1 + int'($urandom % 300);
      a = 32'h0001_0000 + (($urandom % 4096) * 4);
      rdy_pct = 40 + int'($urandom % 61);
      vld_pct = 50 + int'($urandom % 51);
      gnt_pct = 30 + int'($urandom % 71);
      run_xfer(a, 32'(len), len);
    end

    // R2 / R6 largest count
    rdy_pct = 85; vld_pct = 85;
    run_xfer(32'h0004_0000, 32'd16383, 16383);

    // R9 interrupt gating
    wr(A_CTRL, 32'h1);
    begin_xfer(32'h0000_3000, 16, 16);
    wait_idle(v);
    chk("R9 irq with done enabled", 32'(irq), 32'd1);
    wr(A_CTRL, 32'h0);
    chk("R9 irq masked", 32'(irq), 32'd0);
    wr(A_CTRL, 32'h1);
    chk("R9 irq unmasked", 32'(irq), 32'd1);
    wr(A_STAT, 32'h2);
    chk("R7 ack drops irq", 32'(irq), 32'd0);

    // R8 writes while busy ignored
    rdy_pct = 30;
    begin_xfer(32'h0000_2000, 200, 200);
    repeat (5) @(negedge clk);
    wr(A_LEN, 32'd12);
    wr(A_SRC, 32'h0000_9000);
    wait_idle(v);
    chk("R8 beats unchanged by busy write", 32'(beats_seen), 32'd50);
    rd(A_LEN, v);
    chk("R8 count register kept", v, 32'd200);
    rd(A_SRC, v);
    chk("R8 source register kept", v, 32'h0000_2000);
    repeat (5) @(negedge clk);
    rd(A_STAT, v);
    chk("R8 no restart", 32'(v[0]), 32'd0);
    wr(A_STAT, 32'h2);
    rdy_pct = 80;

    // R3 misaligned start
    wr(A_CTRL, 32'h2);
    b0 = bursts_seen;
    exp_req_left = 0; exp_str_left = 0;
    wr(A_SRC, 32'h0000_4002);
    wr(A_LEN, 32'd16);
    rd(A_STAT, v);
    chk("R3 error pending", 32'(v[2]), 32'd1);
    chk("R3 halted", 32'(v[3]), 32'd1);
    chk("R9 irq on error", 32'(irq), 32'd1);
    wr(A_SRC, 32'h0000_5000);
    wr(A_LEN, 32'd16);
    repeat (10) @(negedge clk);
    chk("R3 no memory request", 32'(bursts_seen), 32'(b0));
    rd(A_STAT, v);
    chk("R3 still halted", 32'(v[3]), 32'd1);
    wr(A_CTRL, 32'h4);
    rd(A_STAT, v);
    chk("R10 soft reset clears halt and pending", v, 32'h10);
    chk("R10 irq cleared", 32'(irq), 32'd0);
    run_xfer(32'h0000_5000, 20, 20);

    // R10 drain of an in-flight burst
    gnt_pct = 100; rdy_pct = 0; vld_pct = 60;
    begin_xfer(32'h0000_6000, 64, 64);
    repeat (10) @(negedge clk);
    wr(A_CTRL, 32'h4);
    rd(A_STAT, v);
    chk("R10 reset-done low while draining", 32'(v[4]), 32'd0);
    chk("R10 tvalid low while draining", 32'(m_tvalid), 32'd0);
    repeat (60) @(negedge clk);
    rd(A_STAT, v);
    chk("R10 idle after drain", v, 32'h10);
    chk("R10 no beats leaked", 32'(beats_seen), 32'd0);
    gnt_pct = 60; rdy_pct = 80; vld_pct = 75;
    run_xfer(32'h0000_7000, 37, 37);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule